// File: doc/BRIEF.md
# Indexed Super I/O Configuration Port

This block is the configuration window of a legacy peripheral controller on an 8-bit I/O bus. Two adjacent byte addresses form the window: the lower one selects a register (the index) and the upper one carries that register's data. Behind the window is a file of 256 byte-wide registers. The index is not a separate latch: it lives in register 0 of the file. Reading the data address at index 0 gives zero, not the index.

Most registers are read-only from the bus. A data write whose current index falls in a read-only set is discarded without any trace. The read-only set is: 0x00 to 0xDF, 0xE4, 0xE5, 0xE9 to 0xED, 0xF3, 0xF5, 0xF7, 0xF9 to 0xFB, and 0xFD to 0xFF. A separate enable input, driven by the host bridge, turns the whole window on or off. When it is off, the block ignores every access.

Reset clears the whole file. A small state machine then spends six cycles loading the power-on identity and base-address values, one per cycle. Once that is done it serves bus accesses for as long as reset stays high.

Top module: `sio_cfg_port`

States of the reset sequencer:
- `ST_PRESET` is entered on reset. It writes one default per cycle, selected by a step counter from 0 to 5. It stays in `ST_PRESET` while the step is below 5.
- `ST_PRESET` → `ST_SERVE` is taken on the cycle that writes step 5.
- `ST_SERVE` stays in `ST_SERVE` until the next reset.

## Requirements
- R1: In `ST_SERVE` with the window enabled, a write to the index address (BASE, default 0x3F0) stores the byte into register 0, the index. A read of the index address returns the index.
- R2: A read of the data address (BASE+1) returns the register selected by the index. When the index is 0, it returns 0x00.
- R3: A data write stores the byte into the selected register when the index is one of these writable indices: 0xE0 to 0xE3, 0xE6 to 0xE8, 0xEE to 0xF2, 0xF4, 0xF6, 0xF8, 0xFC.
- R4: A data write is discarded when the index is one of these read-only indices: 0x00 to 0xDF, 0xE4, 0xE5, 0xE9 to 0xED, 0xF3, 0xF5, 0xF7, 0xF9 to 0xFB, 0xFD to 0xFF. The register keeps its value.
- R5: After reset, these registers hold their defaults: 0xE0=0x3C, 0xE2=0x03, 0xE3=0xFC, 0xE6=0xDE, 0xE7=0xFE, 0xE8=0xBE. Every other register, the index included, reads 0x00.
- R6: The defaults are loaded over exactly 6 rising edges after reset is released. During that time reads return 0xFF and bus writes are dropped, including a write in the sixth cycle. Accesses are served from the seventh edge on.
- R7: While `port_en` is low, reads of both addresses return 0xFF and writes are dropped. In particular, the index is left unchanged.
- R8: An access to any address other than BASE and BASE+1 reads 0xFF and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Window enable from the host bridge control |
| io_addr | input | 16 | I/O bus address |
| io_wr | input | 1 | Byte write strobe, sampled on the rising edge |
| io_rd | input | 1 | Byte read strobe; read data is combinational |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, 0xFF when the block does not respond |

## Verification
The reset sequencer and the bus write path can act in the same cycle: the sequencer writes its final default while a host index write arrives. The bench provokes this by driving an index write of 0x5A exactly in the sixth cycle after reset is released. It then judges the outcome in the first serving cycle, by reading back an index of 0x00 and register 0xE8 still holding 0xBE. A second overlap is also covered: a disable that coincides with an index write, with the index checked after the window is enabled again.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

    typedef enum logic [0:0] {
        ST_PRESET = 1'b0,
        ST_SERVE  = 1'b1
    } seq_state_t;

    localparam int unsigned PRESET_STEPS = 6;

    // True when a data write to index k must be discarded.
    function automatic logic is_read_only(input logic [7:0] k);
        logic ro;
        ro = (k <= 8'hDF)
          || (k == 8'hE4) || (k == 8'hE5)
          || (k >= 8'hE9 && k <= 8'hED)
          || (k == 8'hF3) || (k == 8'hF5) || (k == 8'hF7)
          || (k >= 8'hF9 && k <= 8'hFB)
          || (k >= 8'hFD);
        return ro;
    endfunction

    // Register index loaded at preset step s.
    function automatic logic [7:0] preset_index(input logic [2:0] s);
        logic [7:0] r;
        unique case (s)
            3'd0:    r = 8'hE0;
            3'd1:    r = 8'hE2;
            3'd2:    r = 8'hE3;
            3'd3:    r = 8'hE6;
            3'd4:    r = 8'hE7;
            default: r = 8'hE8;
        endcase
        return r;
    endfunction

    // Value loaded at preset step s.
    function automatic logic [7:0] preset_value(input logic [2:0] s);
        logic [7:0] r;
        unique case (s)
            3'd0:    r = 8'h3C;
            3'd1:    r = 8'h03;
            3'd2:    r = 8'hFC;
            3'd3:    r = 8'hDE;
            3'd4:    r = 8'hFE;
            default: r = 8'hBE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sio_cfg_decode.sv
module sio_cfg_decode #(
    parameter int unsigned          ADDR_W    = 16,
    parameter logic [ADDR_W-1:0]    BASE_ADDR = 16'h03F0
) (
    input  logic              port_en,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic              idx_wr,
    output logic              idx_rd,
    output logic              dat_wr,
    output logic              dat_rd
);
    localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + ADDR_W'(1);

    logic hit_idx;
    logic hit_dat;

    always_comb begin
        hit_idx = port_en && (io_addr == BASE_ADDR);
        hit_dat = port_en && (io_addr == DATA_ADDR);
        idx_wr  = hit_idx && io_wr;
        idx_rd  = hit_idx && io_rd;
        dat_wr  = hit_dat && io_wr;
        dat_rd  = hit_dat && io_rd;
    end
endmodule

// File: rtl/sio_cfg_filter.sv
module sio_cfg_filter #(
    parameter int unsigned IDX_W = 8
) (
    input  logic [IDX_W-1:0] index,
    output logic             writable
);
    import sio_cfg_pkg::*;

    always_comb begin
        writable = !is_read_only(8'(index));
    end
endmodule

// File: rtl/sio_cfg_seq.sv
module sio_cfg_seq #(
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              serving,
    output logic              ld_we,
    output logic [IDX_W-1:0]  ld_addr,
    output logic [DATA_W-1:0] ld_data
);
    import sio_cfg_pkg::*;

    localparam int unsigned STEP_W = $clog2(PRESET_STEPS);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(PRESET_STEPS - 1);

    seq_state_t        state_q, state_d;
    logic [STEP_W-1:0] step_q,  step_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PRESET;
            step_q  <= '0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
        end
    end

    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        unique case (state_q)
            ST_PRESET: begin
                if (step_q == LAST_STEP) begin
                    state_d = ST_SERVE;
                    step_d  = '0;
                end else begin
                    step_d  = step_q + STEP_W'(1);
                end
            end
            ST_SERVE: begin
                state_d = ST_SERVE;
            end
            default: state_d = ST_PRESET;
        endcase
    end

    always_comb begin
        serving = 1'b0;
        ld_we   = 1'b0;
        ld_addr = '0;
        ld_data = '0;
        unique case (state_q)
            ST_PRESET: begin
                ld_we   = 1'b1;
                ld_addr = IDX_W'(preset_index(3'(step_q)));
                ld_data = DATA_W'(preset_value(3'(step_q)));
            end
            ST_SERVE: serving = 1'b1;
            default: ;
        endcase
    end

    AST_PRESET_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRESET && step_q == LAST_STEP) |=> (state_q == ST_SERVE)) else $error("preset length"); // R6
    AST_SERVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SERVE) |=> (state_q == ST_SERVE)) else $error("serve left"); // R6
endmodule

// File: rtl/sio_cfg_regfile.sv
module sio_cfg_regfile #(
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wen,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    output logic [IDX_W-1:0]  index,
    output logic [DATA_W-1:0] sel_data
);
    localparam int unsigned NUM_REGS = 1 << IDX_W;

    logic [DATA_W-1:0] mem [NUM_REGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
        end else if (wen) begin
            mem[waddr] <= wdata;
        end
    end

    always_comb begin
        index    = IDX_W'(mem[0]);
        sel_data = mem[index];
    end
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port #(
    parameter int unsigned       ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0,
    parameter int unsigned       IDX_W     = 8,
    parameter int unsigned       DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata
);
    localparam logic [DATA_W-1:0] IDLE_DATA = '1;

    logic idx_wr, idx_rd, dat_wr, dat_rd;
    logic writable, serving;
    logic              ld_we;
    logic [IDX_W-1:0]  ld_addr;
    logic [DATA_W-1:0] ld_data;
    logic              rf_we;
    logic [IDX_W-1:0]  rf_addr;
    logic [DATA_W-1:0] rf_wdata;
    logic [IDX_W-1:0]  index;
    logic [DATA_W-1:0] sel_data;

    sio_cfg_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .port_en(port_en), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .idx_wr(idx_wr), .idx_rd(idx_rd), .dat_wr(dat_wr), .dat_rd(dat_rd)
    );

    sio_cfg_filter #(.IDX_W(IDX_W)) u_flt (
        .index(index), .writable(writable)
    );

    sio_cfg_seq #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .serving(serving),
        .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data)
    );

    sio_cfg_regfile #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_rf (
        .clk(clk), .rst_n(rst_n), .wen(rf_we), .waddr(rf_addr),
        .wdata(rf_wdata), .index(index), .sel_data(sel_data)
    );

    // Write port arbitration: preset has priority, bus only while serving.
    always_comb begin
        rf_we    = 1'b0;
        rf_addr  = '0;
        rf_wdata = io_wdata;
        if (ld_we) begin
            rf_we    = 1'b1;
            rf_addr  = ld_addr;
            rf_wdata = ld_data;
        end else if (serving && idx_wr) begin
            rf_we    = 1'b1;
            rf_addr  = '0;
        end else if (serving && dat_wr && writable) begin
            rf_we    = 1'b1;
            rf_addr  = index;
        end
    end

    always_comb begin
        io_rdata = IDLE_DATA;
        if (serving) begin
            if (idx_rd)
                io_rdata = DATA_W'(index);
            else if (dat_rd)
                io_rdata = (index == '0) ? '0 : sel_data;
        end
    end

    AST_INDEX_TRACKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (serving && idx_wr) |=> (index == IDX_W'($past(io_wdata)))) else $error("index write"); // R1
    AST_ZERO_INDEX_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (serving && dat_rd && index == '0) |-> (io_rdata == '0)) else $error("index 0 read"); // R2
    AST_RO_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (serving && dat_wr && !writable) |=> $stable(sel_data)) else $error("read-only written"); // R4
    AST_OFF_READS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_en) |-> (io_rdata == IDLE_DATA)) else $error("disabled read"); // R7
    AST_OFF_INDEX_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_en && serving) |=> $stable(index)) else $error("disabled write"); // R7
endmodule

// File: tb/sim_sio_cfg_port.sv
module sim_sio_cfg_port;
    localparam logic [15:0] IDXA = 16'h03F0;
    localparam logic [15:0] DATA = 16'h03F1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_en = 1'b1;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sio_cfg_port u0 (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .io_addr(io_addr),
        .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #5 d = io_rdata;
        io_rd = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] k, output logic [7:0] d);
        bus_write(IDXA, k);
        bus_read(DATA, d);
    endtask

    task automatic t_defaults();
        logic [7:0] v;
        do_reset();
        repeat (8) @(negedge clk);
        bus_read(IDXA, v);  check("R5 index after reset", v, 8'h00);
        reg_read(8'hE0, v); check("R5 reg E0", v, 8'h3C);
        reg_read(8'hE2, v); check("R5 reg E2", v, 8'h03);
        reg_read(8'hE3, v); check("R5 reg E3", v, 8'hFC);
        reg_read(8'hE6, v); check("R5 reg E6", v, 8'hDE);
        reg_read(8'hE7, v); check("R5 reg E7", v, 8'hFE);
        reg_read(8'hE8, v); check("R5 reg E8", v, 8'hBE);
        reg_read(8'hE1, v); check("R5 reg E1 cleared", v, 8'h00);
        reg_read(8'h10, v); check("R5 reg 10 cleared", v, 8'h00);
    endtask

    task automatic t_index();
        logic [7:0] v;
        bus_write(IDXA, 8'h55);
        bus_read(IDXA, v);  check("R1 index readback", v, 8'h55);
        bus_write(IDXA, 8'hC3);
        bus_read(IDXA, v);  check("R1 index rewrite", v, 8'hC3);
        bus_write(IDXA, 8'h00);
        bus_read(DATA, v);  check("R2 data at index 0", v, 8'h00);
    endtask

    task automatic t_writable();
        logic [7:0] v;
        logic [7:0] wl [6] = '{8'hF0, 8'hEE, 8'hFC, 8'hF8, 8'hE0, 8'hE1};
        foreach (wl[i]) begin
            bus_write(IDXA, wl[i]);
            bus_write(DATA, 8'hA0 + 8'(i));
            bus_read(DATA, v);
            check("R3 writable register", v, 8'hA0 + 8'(i));
        end
    endtask

    task automatic t_readonly();
        logic [7:0] v;
        logic [7:0] rl [7] = '{8'h20, 8'hE4, 8'hEB, 8'hF3, 8'hF7, 8'hFA, 8'hFF};
        foreach (rl[i]) begin
            bus_write(IDXA, rl[i]);
            bus_write(DATA, 8'h99);
            bus_read(DATA, v);
            check("R4 read-only register", v, 8'h00);
        end
        bus_write(IDXA, 8'h00);
        bus_write(DATA, 8'h77);
        bus_read(IDXA, v); check("R4 data write at index 0", v, 8'h00);
    endtask

    task automatic t_disabled();
        logic [7:0] v;
        bus_write(IDXA, 8'hE6);
        @(negedge clk);
        port_en = 1'b0;
        bus_read(IDXA, v);  check("R7 disabled index read", v, 8'hFF);
        bus_read(DATA, v);  check("R7 disabled data read", v, 8'hFF);
        bus_write(IDXA, 8'h12);
        bus_write(DATA, 8'h34);
        // disable coinciding with an index write
        @(negedge clk);
        io_addr = IDXA; io_wdata = 8'h40; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; port_en = 1'b1;
        bus_read(IDXA, v);  check("R7 index kept while disabled", v, 8'hE6);
        bus_read(DATA, v);  check("R7 data kept while disabled", v, 8'hDE);
    endtask

    task automatic t_other_addr();
        logic [7:0] v;
        bus_write(IDXA, 8'hE7);
        bus_write(16'h03F2, 8'h11);
        bus_write(16'h13F0, 8'h22);
        bus_read(16'h03F2, v); check("R8 foreign address read", v, 8'hFF);
        bus_read(IDXA, v);     check("R8 index unchanged", v, 8'hE7);
        bus_read(DATA, v);     check("R8 data unchanged", v, 8'hFE);
    endtask

    task automatic t_collision();
        logic [7:0] v;
        do_reset();
        @(negedge clk);                 // one edge after release
        io_addr = IDXA; io_rd = 1'b1;
        #5 v = io_rdata;
        io_rd = 1'b0;
        check("R6 read during preset", v, 8'hFF);
        repeat (4) @(negedge clk);      // five edges done
        io_addr = IDXA; io_wdata = 8'h5A; io_wr = 1'b1;
        @(negedge clk);                 // sixth edge: last default loaded
        io_wr = 1'b0;
        io_addr = IDXA; io_rd = 1'b1;
        #5 v = io_rdata;
        io_rd = 1'b0;
        check("R6 write in final preset cycle dropped", v, 8'h00);
        reg_read(8'hE8, v); check("R6 final default intact", v, 8'hBE);
    endtask

    initial begin
        fork
            begin
                t_defaults();
                t_index();
                t_writable();
                t_readonly();
                t_disabled();
                t_other_addr();
                t_collision();
            end
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule